// File: doc/BRIEF.md
# Packed Quadword Compare-to-Mask Unit

This unit takes two 512-bit operand buses, splits them into 64-bit lanes and compares the lanes pairwise. Each active lane yields one result bit, and the bits form an 8-bit mask. A 3-bit predicate picks the relation. It can be equality, inequality, one of the four orderings, or a constant false or true. The orderings use either two's-complement or unsigned arithmetic. A vector-length code sets how many lanes take part. An optional writemask forces selected lanes to zero.

The issuing pipeline presents the operands and the control fields together with a one-cycle start strobe. On the next clock edge the unit registers the mask and raises a valid pulse for one cycle. When the second operand came from memory and broadcast is requested, its lowest lane is compared against every lane of the first operand.

Top module: `qcmp_mask_unit`

## Requirements
- R1: Predicate code 0 (bits 2:0 of `cmp_imm`) sets a lane bit when the first-source lane equals the second-source lane. Code 4 sets it when they differ.
- R2: The predicate codes give these relations of first-source lane A to second-source lane B. Code 1 is A<B, code 2 is A<=B, code 5 is A>=B and code 6 is A>B.
- R3: Code 3 gives 0 in every lane. Code 7 gives 1 in every active lane that the writemask does not block.
- R4: Bits 7:3 of `cmp_imm` have no effect on the mask.
- R5: With `cmp_signed`=1 the orderings treat lanes as two's-complement 64-bit values. With 0 they treat them as unsigned. Codes 0, 3, 4 and 7 do not depend on `cmp_signed`.
- R6: `vec_len` sets the active lane count. Code 0 gives 2 lanes, code 1 gives 4 lanes, and codes 2 and 3 give 8 lanes. Mask bits at or above the active count are 0.
- R7: With `wmask_en`=1 a lane whose `wmask` bit is 0 gets a 0 result bit, and the previous mask is never merged in. With `wmask_en`=0 the value of `wmask` has no effect.
- R8: When `bcast` and `src2_mem` are both 1, bits 63:0 of `src2` are the second operand for every lane. Otherwise lane j uses `src2` bits 64j+63:64j.
- R9: Inputs are sampled at the clock edge where `start` is 1. `mask_out` takes the result at that edge and `mask_valid` is 1 for exactly the following cycle. Without `start` the mask holds and `mask_valid` is 0.
- R10: Synchronous reset clears `mask_out` and `mask_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample strobe for one compare |
| cmp_signed | input | 1 | 1 = two's-complement ordering, 0 = unsigned |
| cmp_imm | input | 8 | Immediate; bits 2:0 give the predicate |
| vec_len | input | 2 | Vector length code (128/256/512, 3 = 512) |
| wmask_en | input | 1 | Enables zeroing writemask |
| wmask | input | 8 | Per-lane writemask |
| bcast | input | 1 | Broadcast request |
| src2_mem | input | 1 | Second source is a memory operand |
| src1 | input | 512 | First source lanes |
| src2 | input | 512 | Second source lanes |
| mask_out | output | 8 | Registered result mask |
| mask_valid | output | 1 | One-cycle strobe after a sampled start |

## Verification
Writemask zeroing and inactive-lane clearing can act on the same mask bits in the same issue. The bench provokes this with a writemask whose set bits reach above the active lane count, together with the constant-true predicate. The result must be 1 only where a lane is both active and enabled by the writemask. Neither rule may override the other. Broadcast is also combined with the writemask and a short vector. These results are checked against hand-computed masks.

// File: rtl/qcmp_pkg.sv
package qcmp_pkg;

    localparam int unsigned QW_BITS   = 64;
    localparam int unsigned QW_LANES  = 8;

    typedef enum logic [2:0] {
        PR_EQ     = 3'd0,
        PR_LT     = 3'd1,
        PR_LE     = 3'd2,
        PR_NEVER  = 3'd3,
        PR_NE     = 3'd4,
        PR_GE     = 3'd5,
        PR_GT     = 3'd6,
        PR_ALWAYS = 3'd7
    } pred_e;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_RSV = 2'd3
    } vlen_e;

    // Raw relation of one lane pair
    typedef struct packed {
        logic same;
        logic below;
    } lane_rel_t;

    function automatic logic pred_hit(pred_e p, lane_rel_t r);
        logic le;
        le = r.below | r.same;
        case (p)
            PR_EQ:     pred_hit = r.same;
            PR_LT:     pred_hit = r.below;
            PR_LE:     pred_hit = le;
            PR_NEVER:  pred_hit = 1'b0;
            PR_NE:     pred_hit = ~r.same;
            PR_GE:     pred_hit = ~r.below;
            PR_GT:     pred_hit = ~le;
            default:   pred_hit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/qcmp_lane_cmp.sv
module qcmp_lane_cmp
    import qcmp_pkg::*;
#(
    parameter int unsigned LANE_W = QW_BITS
) (
    input  logic [LANE_W-1:0] opa,
    input  logic [LANE_W-1:0] opb,
    input  logic              is_signed,
    input  pred_e             pred,
    output logic              hit
);
    // Flipping the sign bit turns a signed compare into an unsigned one
    logic [LANE_W-1:0] ka, kb;
    lane_rel_t         rel;

    always_comb begin
        ka        = opa;
        kb        = opb;
        ka[LANE_W-1] = opa[LANE_W-1] ^ is_signed;
        kb[LANE_W-1] = opb[LANE_W-1] ^ is_signed;
        rel.same  = (opa == opb);
        rel.below = (ka < kb);
        hit       = pred_hit(pred, rel);
    end

endmodule

// File: rtl/qcmp_lane_gate.sv
module qcmp_lane_gate
    import qcmp_pkg::*;
#(
    parameter int unsigned LANES = QW_LANES
) (
    input  vlen_e             vlen,
    input  logic              wm_en,
    input  logic [LANES-1:0]  wm,
    output logic [LANES-1:0]  lane_en
);
    localparam int unsigned MIN_LANES = 2;

    logic [31:0] lane_cnt;

    always_comb begin
        lane_cnt = 32'(MIN_LANES) << vlen;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_gate
        always_comb begin
            lane_en[j] = (32'(j) < lane_cnt) & (~wm_en | wm[j]);
        end
    end

endmodule

// File: rtl/qcmp_mask_unit.sv
module qcmp_mask_unit
    import qcmp_pkg::*;
#(
    parameter int unsigned LANE_W = QW_BITS,
    parameter int unsigned LANES  = QW_LANES,
    parameter int unsigned IMM_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cmp_signed,
    input  logic [IMM_W-1:0]        cmp_imm,
    input  logic [1:0]              vec_len,
    input  logic                    wmask_en,
    input  logic [LANES-1:0]        wmask,
    input  logic                    bcast,
    input  logic                    src2_mem,
    input  logic [LANE_W*LANES-1:0] src1,
    input  logic [LANE_W*LANES-1:0] src2,
    output logic [LANES-1:0]        mask_out,
    output logic                    mask_valid
);
    localparam int unsigned PRED_W = 3;

    pred_e            pred;
    logic             use_bc;
    logic [LANES-1:0] hit;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] mask_d;
    logic [LANES-1:0] mask_q;
    logic             vld_q;

    always_comb begin
        pred   = pred_e'(cmp_imm[PRED_W-1:0]);
        use_bc = bcast & src2_mem;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] b_sel;
        always_comb begin
            b_sel = use_bc ? src2[LANE_W-1:0] : src2[j*LANE_W +: LANE_W];
        end
        qcmp_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
            .opa       (src1[j*LANE_W +: LANE_W]),
            .opb       (b_sel),
            .is_signed (cmp_signed),
            .pred      (pred),
            .hit       (hit[j])
        );
    end

    qcmp_lane_gate #(.LANES(LANES)) u_gate (
        .vlen    (vlen_e'(vec_len)),
        .wm_en   (wmask_en),
        .wm      (wmask),
        .lane_en (lane_en)
    );

    always_comb begin
        mask_d = hit & lane_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= start;
            if (start) begin
                mask_q <= mask_d;
            end
        end
    end

    assign mask_out   = mask_q;
    assign mask_valid = vld_q;

endmodule

// File: rtl/qcmp_mask_sva.sv
module qcmp_mask_sva #(
    parameter int unsigned LANES = 8,
    parameter int unsigned IMM_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [IMM_W-1:0] cmp_imm,
    input logic [1:0]       vec_len,
    input logic             wmask_en,
    input logic [LANES-1:0] wmask,
    input logic [LANES-1:0] mask_out,
    input logic             mask_valid
);

    p_valid_after_start_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> mask_valid);

    p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> !mask_valid);

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(mask_out));

    p_short_vec_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (start && vec_len == 2'd0) |=> ((mask_out >> 2) == '0));

    p_wmask_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (start && wmask_en) |=> ((mask_out & ~$past(wmask)) == '0));

    p_never_pred_r3: assert property (@(posedge clk) disable iff (rst)
        (start && cmp_imm[2:0] == 3'd3) |=> (mask_out == '0));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!mask_valid && mask_out == '0));

endmodule

bind qcmp_mask_unit qcmp_mask_sva #(.LANES(LANES), .IMM_W(IMM_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmp_imm    (cmp_imm),
    .vec_len    (vec_len),
    .wmask_en   (wmask_en),
    .wmask      (wmask),
    .mask_out   (mask_out),
    .mask_valid (mask_valid)
);

// File: tb/test_qcmp_mask_unit.sv
`timescale 1ns/1ps
module test_qcmp_mask_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cmp_signed = 1'b0;
    logic [7:0]   cmp_imm = '0;
    logic [1:0]   vec_len = 2'd2;
    logic         wmask_en = 1'b0;
    logic [7:0]   wmask = '0;
    logic         bcast = 1'b0;
    logic         src2_mem = 1'b0;
    logic [511:0] src1 = '0;
    logic [511:0] src2 = '0;
    logic [7:0]   mask_out;
    logic         mask_valid;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    qcmp_mask_unit i_qcmp_mask_unit (
        .clk(clk), .rst(rst), .start(start), .cmp_signed(cmp_signed),
        .cmp_imm(cmp_imm), .vec_len(vec_len), .wmask_en(wmask_en),
        .wmask(wmask), .bcast(bcast), .src2_mem(src2_mem),
        .src1(src1), .src2(src2), .mask_out(mask_out), .mask_valid(mask_valid)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Independent model written from the requirements
    function automatic logic [7:0] model();
        logic [7:0] m;
        int n;
        n = (vec_len == 2'd0) ? 2 : (vec_len == 2'd1) ? 4 : 8;
        m = '0;
        for (int j = 0; j < 8; j++) begin
            logic [63:0] a, b;
            logic lt, eq, r;
            a  = src1[j*64 +: 64];
            b  = (bcast && src2_mem) ? src2[63:0] : src2[j*64 +: 64];
            lt = cmp_signed ? ($signed(a) < $signed(b)) : (a < b);
            eq = (a == b);
            case (cmp_imm[2:0])
                3'd0: r = eq;
                3'd1: r = lt;
                3'd2: r = lt || eq;
                3'd3: r = 1'b0;
                3'd4: r = !eq;
                3'd5: r = !lt;
                3'd6: r = !(lt || eq);
                default: r = 1'b1;
            endcase
            if (j >= n) r = 1'b0;
            if (wmask_en && !wmask[j]) r = 1'b0;
            m[j] = r;
        end
        return m;
    endfunction

    // Issue one compare; returns the registered mask
    task automatic issue(string req, output logic [7:0] got);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " valid"}, {7'd0, mask_valid}, 8'h01);
        got = mask_out;
    endtask

    task automatic issue_model(string req);
        logic [7:0] g, e;
        e = model();
        issue(req, g);
        chk(req, g, e);
    endtask

    task automatic set_lanes(logic [63:0] a [8], logic [63:0] b [8]);
        for (int j = 0; j < 8; j++) begin
            src1[j*64 +: 64] = a[j];
            src2[j*64 +: 64] = b[j];
        end
    endtask

    task automatic t_reset();
        chk("R10 reset mask", mask_out, 8'h00);
        chk("R10 reset valid", {7'd0, mask_valid}, 8'h00);
    endtask

    task automatic t_eq_ne();
        logic [7:0] g;
        logic [63:0] a [8] = '{64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8};
        logic [63:0] b [8] = '{64'd1, 64'd9, 64'd3, 64'd0, 64'd5, 64'd6, 64'd0, 64'd8};
        set_lanes(a, b);
        vec_len = 2'd2; cmp_signed = 0; wmask_en = 0; bcast = 0; src2_mem = 0;
        cmp_imm = 8'd0; issue("R1 equal", g);     chk("R1 equal", g, 8'b1011_0101);
        cmp_imm = 8'd4; issue("R1 not-equal", g); chk("R1 not-equal", g, 8'b0100_1010);
    endtask

    task automatic t_order();
        logic [7:0] g;
        logic [63:0] a [8] = '{64'd5, 64'd5, 64'd5, 64'd0, 64'd9, 64'd1, 64'd7, 64'd3};
        logic [63:0] b [8] = '{64'd6, 64'd5, 64'd4, 64'd0, 64'd2, 64'd8, 64'd7, 64'd9};
        set_lanes(a, b);
        vec_len = 2'd2; cmp_signed = 0; wmask_en = 0; bcast = 0; src2_mem = 0;
        cmp_imm = 8'd1; issue("R2 lt", g); chk("R2 lt", g, 8'b1010_0001);
        cmp_imm = 8'd2; issue("R2 le", g); chk("R2 le", g, 8'b1110_1011);
        cmp_imm = 8'd5; issue("R2 ge", g); chk("R2 ge", g, 8'b0101_1110);
        cmp_imm = 8'd6; issue("R2 gt", g); chk("R2 gt", g, 8'b0001_0100);
    endtask

    task automatic t_const();
        logic [7:0] g;
        vec_len = 2'd2; wmask_en = 0;
        cmp_imm = 8'd3; issue("R3 never", g);  chk("R3 never", g, 8'h00);
        cmp_imm = 8'd7; issue("R3 always", g); chk("R3 always", g, 8'hFF);
    endtask

    task automatic t_reserved_imm();
        for (int p = 0; p < 8; p++) begin
            cmp_imm = {5'b10110, 3'(p)};
            issue_model("R4 reserved imm bits");
        end
    endtask

    task automatic t_signedness();
        logic [7:0] g;
        logic [63:0] a [8] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
                               64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 64'd10};
        logic [63:0] b [8] = '{64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                               64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 64'd2};
        set_lanes(a, b);
        vec_len = 2'd2; wmask_en = 0; bcast = 0; src2_mem = 0;
        cmp_imm = 8'd1;
        cmp_signed = 0; issue("R5 unsigned lt", g); chk("R5 unsigned lt", g, 8'b0100_1010);
        cmp_signed = 1; issue("R5 signed lt", g);   chk("R5 signed lt", g, 8'b0100_0101);
        cmp_imm = 8'd0; issue("R5 signed eq", g);   chk("R5 signed eq", g, 8'b0011_0000);
        for (int p = 0; p < 8; p++) begin
            cmp_imm = 8'(p);
            cmp_signed = 1; issue_model("R5 signed model");
            cmp_signed = 0; issue_model("R5 unsigned model");
        end
    endtask

    task automatic t_vlen();
        logic [7:0] g;
        cmp_imm = 8'd7; wmask_en = 0;
        vec_len = 2'd0; issue("R6 128", g); chk("R6 128", g, 8'h03);
        vec_len = 2'd1; issue("R6 256", g); chk("R6 256", g, 8'h0F);
        vec_len = 2'd2; issue("R6 512", g); chk("R6 512", g, 8'hFF);
        vec_len = 2'd3; issue("R6 code3", g); chk("R6 code3", g, 8'hFF);
    endtask

    task automatic t_wmask();
        logic [7:0] g;
        cmp_imm = 8'd7; vec_len = 2'd2;
        wmask_en = 1; wmask = 8'hA5; issue("R7 zeroing", g);  chk("R7 zeroing", g, 8'hA5);
        wmask_en = 0; wmask = 8'h00; issue("R7 disabled", g); chk("R7 disabled", g, 8'hFF);
        // Overlap: writemask above active lane count
        wmask_en = 1; wmask = 8'hFF; vec_len = 2'd0; issue("R7 R6 overlap", g); chk("R7 R6 overlap", g, 8'h03);
        wmask = 8'hFE; vec_len = 2'd1; issue("R7 R6 overlap", g); chk("R7 R6 overlap", g, 8'h0E);
        wmask_en = 0;
    endtask

    task automatic t_bcast();
        logic [7:0] g;
        logic [63:0] a [8] = '{64'd0, 64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7};
        logic [63:0] b [8] = '{64'd3, 64'd100, 64'd100, 64'd100, 64'd100, 64'd100, 64'd100, 64'd100};
        set_lanes(a, b);
        cmp_imm = 8'd1; cmp_signed = 0; vec_len = 2'd2; wmask_en = 0;
        bcast = 1; src2_mem = 1; issue("R8 bcast", g);     chk("R8 bcast", g, 8'h07);
        bcast = 1; src2_mem = 0; issue("R8 reg src", g);   chk("R8 reg src", g, 8'hFF);
        bcast = 0; src2_mem = 1; issue("R8 no bcast", g);  chk("R8 no bcast", g, 8'hFF);
        bcast = 1; src2_mem = 1; wmask_en = 1; wmask = 8'h06; vec_len = 2'd1;
        issue("R8 R7 bcast wm", g); chk("R8 R7 bcast wm", g, 8'h06);
        bcast = 0; src2_mem = 0; wmask_en = 0;
    endtask

    task automatic t_timing();
        logic [7:0] g, held;
        cmp_imm = 8'd7; vec_len = 2'd1;
        issue("R9 pulse", g);
        held = g;
        cmp_imm = 8'd3; vec_len = 2'd2; // changed without start
        @(negedge clk);
        chk("R9 valid drop", {7'd0, mask_valid}, 8'h00);
        chk("R9 mask hold", mask_out, held);
        @(negedge clk);
        chk("R9 mask hold", mask_out, held);
    endtask

    task automatic t_reset_mid();
        logic [7:0] g;
        cmp_imm = 8'd7; vec_len = 2'd2;
        issue("R10 pre", g);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R10 reset mask", mask_out, 8'h00);
        chk("R10 reset valid", {7'd0, mask_valid}, 8'h00);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_eq_ne();
        t_order();
        t_const();
        t_reserved_imm();
        t_signedness();
        t_vlen();
        t_wmask();
        t_bcast();
        t_timing();
        t_reset_mid();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule